// File: doc/BRIEF.md
# Split-Array Last-Level Cache Slice

This block is one slice of a last-level cache whose sets live in two separate physical arrays. A small, fast base array holds one third of the sets. A larger, slower extension array holds the other two thirds. Two bits taken from the set-index part of the request address pick the array before any tag is compared. Each array keeps its own tags, valid bits, line data and tree pseudo-LRU state. A lookup compares the request tag against all 16 ways of one set, and only in the chosen array.

Requests arrive over a valid/ready handshake, one at a time. A request is either a read or a fill. A read answers with a hit flag, the array that served it and the 64-byte line. A fill writes a line into the set and array that its address selects, so a miss can be installed where later lookups will find it. Every response is a one-cycle pulse. Accesses to the extension array take a fixed four cycles longer than accesses to the base array.

Top module: `cache_slice`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, and every read misses until a fill installs a line.
- R2: Address fields are: byte offset in bits [5:0], low set bits L in [7:6], region in [9:8], and tag in [15:8]. Region 0 selects base set L. Region 1 selects extension set {0,L}. Region 2 selects extension set {1,L}. Region 3 selects extension set {L[0],L}. `rsp_ext` is 1 exactly when the extension array was used.
- R3: Reads and fills to the base array answer with a one-cycle `rsp_valid` pulse 2 cycles after the accepting clock edge. Extension accesses answer 6 cycles after it, which is 4 cycles later.
- R4: A read whose tag is resident in the chosen set gives `rsp_hit`=1 and returns the most recently filled line for that tag. A fill sets the valid bit of the way it writes.
- R5: A read miss gives `rsp_hit`=0 and an all-zero `rsp_line`. A fill response also carries `rsp_hit`=0 and a zero line.
- R6: The two arrays share nothing. Fills and hits in one array never evict, validate or reorder lines in the other array.
- R7: Each set holds 16 ways. Sixteen distinct tags filled into one set all stay resident.
- R8: A fill of a non-resident tag takes the lowest-numbered invalid way. If all ways are valid, it takes the tree pseudo-LRU victim. Hits and fills mark their way as most recent. After fills of tags T0..T15 into an empty set, filling T16 evicts T0. If a hit on T0 comes before the T16 fill, T8 is evicted instead.
- R9: A fill whose tag is already resident overwrites that way in place, so at most one way of a set ever matches a tag.
- R10: While a request is outstanding, `req_ready` is 0 and no new request is accepted. `req_ready` returns to 1 in the same cycle that the response is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Slice can accept a request |
| req_op | input | 1 | 0 = read, 1 = fill |
| req_addr | input | 16 | Byte address of the request |
| req_line | input | 512 | Line written by a fill |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | Read found its tag |
| rsp_ext | output | 1 | Access went to the extension array |
| rsp_line | output | 512 | Line returned on a read hit, zero otherwise |

## Verification
The embedded properties watch several things on every cycle. They check that no set ever holds two matching ways, that a written way becomes valid, and that response pulses last one cycle. They check that the gap from acceptance to response matches the array that was chosen, that a new request is only taken when one is offered, and that miss responses carry no data. Other behaviour needs directed scenarios, because it only shows over long sequences. This covers the address-to-array mapping with region 3 folding onto the extension sets, the exact victim after the pseudo-LRU history, and the isolation of the two arrays' replacement state. It also covers in-place refill returning the newest line.

// File: rtl/cslice_pkg.sv
package cslice_pkg;

    localparam int WAYS       = 16;
    localparam int WAY_W      = $clog2(WAYS);
    localparam int PLRU_W     = WAYS - 1;
    localparam int LINE_BYTES = 64;
    localparam int LINE_BITS  = LINE_BYTES * 8;
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int ADDR_W     = 16;
    localparam int BASE_SETS  = 4;
    localparam int LOW_W      = $clog2(BASE_SETS);
    localparam int EXT_SETS   = 2 * BASE_SETS;
    localparam int EXT_IDX_W  = LOW_W + 1;
    localparam int REGION_LSB = OFF_W + LOW_W;
    localparam int TAG_W      = ADDR_W - REGION_LSB;
    localparam int BASE_LAT   = 2;
    localparam int EXT_EXTRA  = 4;
    localparam int EXT_LAT    = BASE_LAT + EXT_EXTRA;
    localparam int CNT_W      = $clog2(EXT_LAT + 1);

    typedef enum logic {
        OP_READ = 1'b0,
        OP_FILL = 1'b1
    } op_e;

    typedef struct packed {
        logic                 ext;
        logic [EXT_IDX_W-1:0] set;
        logic [TAG_W-1:0]     tag;
    } route_t;

    // Region bits steer the set to one array; region 3 folds on low[0].
    function automatic route_t route_addr(input logic [ADDR_W-1:0] a);
        route_t             r;
        logic [LOW_W-1:0]   low;
        logic [1:0]         region;
        low    = a[OFF_W +: LOW_W];
        region = a[REGION_LSB +: 2];
        r.tag  = a[ADDR_W-1 -: TAG_W];
        unique case (region)
            2'd0: begin r.ext = 1'b0; r.set = {1'b0, low}; end
            2'd1: begin r.ext = 1'b1; r.set = {1'b0, low}; end
            2'd2: begin r.ext = 1'b1; r.set = {1'b1, low}; end
            default: begin r.ext = 1'b1; r.set = {low[0], low}; end
        endcase
        return r;
    endfunction

    // Heap-ordered tree: node n at bit n-1; bit 1 points the victim right.
    function automatic logic [WAY_W-1:0] plru_pick(input logic [PLRU_W-1:0] t);
        int n;
        n = 1;
        for (int l = 0; l < WAY_W; l++) begin
            n = 2 * n + int'(t[n-1]);
        end
        return WAY_W'(n - WAYS);
    endfunction

    function automatic logic [PLRU_W-1:0] plru_touch(input logic [PLRU_W-1:0] t,
                                                     input logic [WAY_W-1:0]  w);
        logic [PLRU_W-1:0] r;
        logic              dir;
        int                n;
        r = t;
        n = 1;
        for (int l = 0; l < WAY_W; l++) begin
            dir      = w[WAY_W-1-l];
            r[n-1]   = ~dir;
            n        = 2 * n + int'(dir);
        end
        return r;
    endfunction

endpackage

// File: rtl/cs_array.sv
module cs_array
    import cslice_pkg::*;
#(
    parameter int SETS  = 4,
    parameter int SET_W = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SET_W-1:0]     lk_set,
    input  logic [TAG_W-1:0]     lk_tag,
    output logic                 lk_hit,
    output logic [WAY_W-1:0]     lk_way,
    output logic [WAY_W-1:0]     lk_victim,
    output logic [LINE_BITS-1:0] lk_line,
    input  logic                 wr_en,
    input  logic                 wr_fill,
    input  logic [WAY_W-1:0]     wr_way,
    input  logic [LINE_BITS-1:0] wr_line
);

    logic [TAG_W-1:0]     tag_q   [SETS][WAYS];
    logic [LINE_BITS-1:0] line_q  [SETS][WAYS];
    logic [WAYS-1:0]      valid_q [SETS];
    logic [PLRU_W-1:0]    plru_q  [SETS];
    logic [WAYS-1:0]      match;

    always_comb begin
        lk_way    = '0;
        lk_victim = plru_pick(plru_q[lk_set]);
        for (int w = 0; w < WAYS; w++) begin
            match[w] = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) lk_way = WAY_W'(w);
        end
        if (!(&valid_q[lk_set])) begin
            for (int w = WAYS - 1; w >= 0; w--) begin
                if (!valid_q[lk_set][w]) lk_victim = WAY_W'(w);
            end
        end
        lk_hit  = |match;
        lk_line = line_q[lk_set][lk_way];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                plru_q[s]  <= '0;
            end
        end else if (wr_en) begin
            plru_q[lk_set] <= plru_touch(plru_q[lk_set], wr_way);
            if (wr_fill) valid_q[lk_set][wr_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && wr_fill) begin
            tag_q[lk_set][wr_way]  <= lk_tag;
            line_q[lk_set][wr_way] <= wr_line;
        end
    end

    logic             fill_seen_q;
    logic [SET_W-1:0] fset_q;
    logic [WAY_W-1:0] fway_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_seen_q <= 1'b0;
            fset_q      <= '0;
            fway_q      <= '0;
        end else begin
            fill_seen_q <= wr_en && wr_fill;
            fset_q      <= lk_set;
            fway_q      <= wr_way;
        end
    end

    assert_single_match_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));

    assert_fill_sets_valid_R4: assert property (@(posedge clk) disable iff (rst)
        fill_seen_q |-> valid_q[fset_q][fway_q]);

endmodule

// File: rtl/cache_slice.sv
module cache_slice
    import cslice_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_op,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [LINE_BITS-1:0] req_line,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic                 rsp_ext,
    output logic [LINE_BITS-1:0] rsp_line
);

    logic                 busy_q;
    logic [CNT_W-1:0]     cnt_q;
    op_e                  op_q;
    route_t               route_q;
    logic [LINE_BITS-1:0] line_q;
    logic                 accept;
    logic                 fire;
    route_t               route_in;

    logic [1:0]           hit_v;
    logic [1:0]           wr_en_v;
    logic [WAY_W-1:0]     way_v  [2];
    logic [WAY_W-1:0]     vic_v  [2];
    logic [WAY_W-1:0]     wway_v [2];
    logic [LINE_BITS-1:0] data_v [2];

    assign req_ready = !busy_q;
    assign accept    = req_valid && !busy_q;
    assign fire      = busy_q && (cnt_q == '0);
    assign route_in  = route_addr(req_addr);

    for (genvar g = 0; g < 2; g++) begin : g_arr
        localparam int SETS_G = (g == 0) ? BASE_SETS : EXT_SETS;
        localparam int SW_G   = (g == 0) ? LOW_W : EXT_IDX_W;
        logic [SW_G-1:0] set_g;
        logic            sel_g;

        assign set_g     = route_q.set[SW_G-1:0];
        assign sel_g     = (route_q.ext == 1'(g));
        assign wr_en_v[g] = fire && sel_g && ((op_q == OP_FILL) || hit_v[g]);
        assign wway_v[g] = (op_q == OP_FILL && !hit_v[g]) ? vic_v[g] : way_v[g];

        cs_array #(.SETS(SETS_G), .SET_W(SW_G)) u_arr (
            .clk       (clk),
            .rst       (rst),
            .lk_set    (set_g),
            .lk_tag    (route_q.tag),
            .lk_hit    (hit_v[g]),
            .lk_way    (way_v[g]),
            .lk_victim (vic_v[g]),
            .lk_line   (data_v[g]),
            .wr_en     (wr_en_v[g]),
            .wr_fill   (op_q == OP_FILL),
            .wr_way    (wway_v[g]),
            .wr_line   (line_q)
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            cnt_q     <= '0;
            op_q      <= OP_READ;
            route_q   <= '0;
            line_q    <= '0;
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_ext   <= 1'b0;
            rsp_line  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (accept) begin
                busy_q  <= 1'b1;
                op_q    <= op_e'(req_op);
                route_q <= route_in;
                line_q  <= req_line;
                cnt_q   <= route_in.ext ? CNT_W'(EXT_LAT - 1) : CNT_W'(BASE_LAT - 1);
            end else if (fire) begin
                busy_q    <= 1'b0;
                rsp_valid <= 1'b1;
                rsp_ext   <= route_q.ext;
                rsp_hit   <= (op_q == OP_READ) && hit_v[route_q.ext];
                rsp_line  <= ((op_q == OP_READ) && hit_v[route_q.ext]) ? data_v[route_q.ext] : '0;
            end else if (busy_q) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // Age of the outstanding request, counted independently of cnt_q.
    logic [CNT_W:0] age_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            age_q <= '0;
        end else if (accept) begin
            age_q <= '0;
        end else if (busy_q && age_q != '1) begin
            age_q <= age_q + 1'b1;
        end
    end

    assert_latency_by_array_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (age_q == (rsp_ext ? (CNT_W+1)'(EXT_LAT) : (CNT_W+1)'(BASE_LAT))));

    assert_rsp_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_accept_needs_request_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> $past(req_valid));

    assert_miss_has_no_data_R5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_line == '0));

endmodule

// File: tb/tb_cache_slice.sv
module tb_cache_slice;
    import cslice_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 11;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 req_valid;
    logic                 req_ready;
    logic                 req_op;
    logic [ADDR_W-1:0]    req_addr;
    logic [LINE_BITS-1:0] req_line;
    logic                 rsp_valid;
    logic                 rsp_hit;
    logic                 rsp_ext;
    logic [LINE_BITS-1:0] rsp_line;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cache_slice dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_line(req_line),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ext(rsp_ext), .rsp_line(rsp_line)
    );

    // op, addr, salt, expected hit, expected extension
    localparam logic [34:0] VEC [NV] = '{
        {1'b0, 16'h0040, 16'h0000, 1'b0, 1'b0},
        {1'b1, 16'h0040, 16'h0001, 1'b0, 1'b0},
        {1'b0, 16'h0040, 16'h0001, 1'b1, 1'b0},
        {1'b0, 16'h0140, 16'h0000, 1'b0, 1'b1},
        {1'b1, 16'h0140, 16'h0002, 1'b0, 1'b1},
        {1'b0, 16'h0140, 16'h0002, 1'b1, 1'b1},
        {1'b0, 16'h0340, 16'h0000, 1'b0, 1'b1},
        {1'b1, 16'h0340, 16'h0003, 1'b0, 1'b1},
        {1'b0, 16'h0340, 16'h0003, 1'b1, 1'b1},
        {1'b0, 16'h0240, 16'h0000, 1'b0, 1'b1},
        {1'b0, 16'h0050, 16'h0001, 1'b1, 1'b0}
    };

    function automatic logic [LINE_BITS-1:0] mkline(input logic [15:0] a, input logic [15:0] s);
        return {16{{a & 16'hFFC0, s}}};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_op(input bit op, input logic [15:0] addr, input logic [15:0] salt,
                         input bit exp_hit, input bit exp_ext, input string req);
        int n;
        logic [LINE_BITS-1:0] exp_line;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10", "ready before request", 64'(req_ready), 64'd1);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = addr;
        req_line  = mkline(addr, salt);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R10", "ready while outstanding", 64'(req_ready), 64'd0);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!rsp_valid && n < 40);
        chk(n == (exp_ext ? EXT_LAT : BASE_LAT), "R3", "latency", 64'(n),
            64'(exp_ext ? EXT_LAT : BASE_LAT));
        chk(req_ready == 1'b1, "R10", "ready with response", 64'(req_ready), 64'd1);
        chk(rsp_ext == exp_ext, "R2", "array select", 64'(rsp_ext), 64'(exp_ext));
        chk(rsp_hit == exp_hit, req, "hit flag", 64'(rsp_hit), 64'(exp_hit));
        exp_line = (exp_hit && !op) ? mkline(addr, salt) : '0;
        chk(rsp_line == exp_line, exp_hit ? "R4" : "R5", "line", rsp_line[63:0], exp_line[63:0]);
    endtask

    function automatic logic [15:0] ea(input int k);
        return 16'((k << 10) | 16'h0100);
    endfunction
    function automatic logic [15:0] eb(input int k);
        return 16'((k << 10) | 16'h0180);
    endfunction
    function automatic logic [15:0] ba(input int k);
        return 16'(k << 10);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_op = 1'b0; req_addr = '0; req_line = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle state after reset
        chk(req_ready == 1'b1, "R1", "ready after reset", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0, "R1", "no response after reset", 64'(rsp_valid), 64'd0);

        // Table walk: R1 first read misses, R2 mapping incl. region 3 fold, R4, R5
        for (int i = 0; i < NV; i++) begin
            do_op(VEC[i][34], VEC[i][33:18], VEC[i][17:2], VEC[i][1], VEC[i][0],
                  VEC[i][1] ? "R4" : "R5");
        end

        // R9: refill of a resident tag replaces it in place
        do_op(1'b1, 16'h0040, 16'h0009, 1'b0, 1'b0, "R9");
        do_op(1'b0, 16'h0040, 16'h0009, 1'b1, 1'b0, "R9");

        // R7: sixteen tags in one extension set all stay resident
        for (int k = 0; k < 16; k++) do_op(1'b1, ea(k), 16'(k), 1'b0, 1'b1, "R7");
        for (int k = 0; k < 16; k++) do_op(1'b0, ea(k), 16'(k), 1'b1, 1'b1, "R7");

        // R6: base-array activity on the matching low bits
        for (int k = 0; k < 3; k++) do_op(1'b1, ba(k), 16'(16'h100 + k), 1'b0, 1'b0, "R6");
        for (int k = 2; k >= 0; k--) do_op(1'b0, ba(k), 16'(16'h100 + k), 1'b1, 1'b0, "R6");

        // R8: next fill evicts T0, unaffected by base-array traffic (R6)
        do_op(1'b1, ea(16), 16'h0016, 1'b0, 1'b1, "R8");
        do_op(1'b0, ea(0),  16'h0000, 1'b0, 1'b1, "R8");
        do_op(1'b0, ea(1),  16'h0001, 1'b1, 1'b1, "R8");
        do_op(1'b0, ea(16), 16'h0016, 1'b1, 1'b1, "R8");
        do_op(1'b0, ba(0),  16'h0100, 1'b1, 1'b0, "R6");

        // R8: a hit on T0 before the 17th fill moves the victim to T8
        for (int k = 0; k < 16; k++) do_op(1'b1, eb(k), 16'(16'h200 + k), 1'b0, 1'b1, "R8");
        do_op(1'b0, eb(0), 16'h0200, 1'b1, 1'b1, "R8");
        do_op(1'b1, eb(16), 16'h0216, 1'b0, 1'b1, "R8");
        do_op(1'b0, eb(8), 16'h0208, 1'b0, 1'b1, "R8");
        do_op(1'b0, eb(0), 16'h0200, 1'b1, 1'b1, "R8");
        do_op(1'b0, eb(16), 16'h0216, 1'b1, 1'b1, "R8");

        // R1: a second reset clears every line
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        do_op(1'b0, 16'h0040, 16'h0000, 1'b0, 1'b0, "R1");
        do_op(1'b0, ea(1), 16'h0000, 1'b0, 1'b1, "R1");

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule